// File: doc/BRIEF.md
# Input Pulse Width Capture Unit

This unit measures the high and low phases of a digital input waveform in clock ticks. A source selector picks one of several channel pins. The chosen pin goes through a synchronizer and then an optional glitch filter with a programmable window. The unit then counts how many clock cycles the qualified level stays high and how many it stays low.

Each falling edge stores the length of the high phase that just ended. Each rising edge stores the length of the low phase that just ended. Every store raises its own sticky status flag, which is cleared by writing a one. The flags are gated by per-flag enable and mask inputs onto one interrupt line. Capture runs only while the mode input selects capture. After entering capture, the first edge seen only starts the measurement, so a partial phase is never reported.

Top module: `pulse_width_capture`

## Requirements
- R1: After reset, `hi_count`, `lo_count` and `status` are all zero and `irq` is low.
- R2: Capture runs only while `mode` equals 2'b10. For any other mode value, edges on the input change neither `hi_count`, `lo_count` nor `status`.
- R3: After capture is entered, the first qualified edge stores nothing. It only starts the first full phase. Each later edge stores the phase that just ended.
- R4: On a falling edge of the qualified input, `hi_count` takes the number of clock cycles the qualified input was high, and `status` bit 1 is set.
- R5: On a rising edge of the qualified input, `lo_count` takes the number of clock cycles the qualified input was low, and `status` bit 0 is set.
- R6: A phase count saturates at 2^CNT_W-1 instead of wrapping. The count for the next phase starts again from 1.
- R7: Driving `sts_clr` bit b high for one cycle clears `status` bit b. If a store sets that bit in the same cycle, the bit stays set.
- R8: `irq` is high exactly when some `status` bit is 1 while its `irq_en` bit is 1 and its `irq_mask` bit is 0.
- R9: The measured pin is `pin_in[src_sel]`. Edges on other pins have no effect.
- R10: With `filt_en` high, the qualified level follows a new input level only after that level has been sampled for `filt_win` consecutive cycles (a window of 0 acts as 1). Shorter pulses are dropped, and longer pulses keep their width. With `filt_en` low, the level passes unfiltered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that is counted |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode; 2'b10 selects capture |
| pin_in | input | NUM_CH | Input pins of all channels |
| src_sel | input | SEL_W | Index of the pin to measure |
| filt_en | input | 1 | Glitch filter enable |
| filt_win | input | WIN_W | Filter window length in cycles |
| sts_clr | input | 2 | Write-one-to-clear strobes for the status flags (bit 1 high phase, bit 0 low phase) |
| irq_en | input | 2 | Interrupt enable per status flag |
| irq_mask | input | 2 | Interrupt mask per status flag, 1 suppresses |
| hi_count | output | CNT_W | Length of the last completed high phase |
| lo_count | output | CNT_W | Length of the last completed low phase |
| status | output | 2 | Sticky capture flags: bit 1 high stored, bit 0 low stored |
| irq | output | 1 | Interrupt request |

## Verification
The main function is driven with square waves of unequal and changing high and low widths. Exact counts show that each edge stores the phase that just ended and that the counter restarts from 1. A second trial with the same pattern in a non-capture mode, and one on a pin that is not selected, show that both are ignored. Re-entering capture and checking that the first rising edge stores nothing separates arming from storing. Filtered runs use pulses one cycle shorter than the window (dropped), exactly the window (kept), and longer (width kept). A phase longer than the counter range shows saturation against wrap-around.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam logic [1:0] MODE_CAPTURE = 2'b10;
  localparam int NUM_PH = 2;
  localparam int PH_LO = 0;
  localparam int PH_HI = 1;
endpackage

// File: rtl/pwc_input.sv
module pwc_input #(
  parameter int NUM_CH = 8,
  parameter int SEL_W = 3,
  parameter int SYNC_STAGES = 2,
  parameter int WIN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin_in,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic              filt_en,
  input  logic [WIN_W-1:0]  filt_win,
  output logic              sync_lvl,
  output logic              filt_lvl
);
  // true when the level has been held long enough to be accepted
  function automatic logic window_met(input logic en, input logic [WIN_W-1:0] held,
                                      input logic [WIN_W-1:0] win);
    logic [WIN_W:0] seen;
    seen = {1'b0, held} + 1'b1;
    return !en || (seen >= {1'b0, win});
  endfunction

  logic sel_pin;
  assign sel_pin = ({1'b0, src_sel} < (SEL_W+1)'(NUM_CH)) ? pin_in[src_sel] : 1'b0;

  logic [SYNC_STAGES:0] chain;
  assign chain[0] = sel_pin;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic stage_q;
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q <= 1'b0;
      else        stage_q <= chain[g];
    end
    assign chain[g+1] = stage_q;
  end

  assign sync_lvl = chain[SYNC_STAGES];

  logic [WIN_W-1:0] held_q;
  logic             filt_q;
  logic             differs;
  assign differs = sync_lvl != filt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      held_q <= '0;
    end else if (differs && window_met(filt_en, held_q, filt_win)) begin
      filt_q <= sync_lvl;
      held_q <= '0;
    end else if (differs) begin
      held_q <= held_q + 1'b1;
    end else begin
      held_q <= '0;
    end
  end

  assign filt_lvl = filt_q;
endmodule

// File: rtl/pwc_phase.sv
module pwc_phase
  import pwc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         active,
  input  logic                         level,
  output logic [NUM_PH-1:0][CNT_W-1:0] ph_res,
  output logic [NUM_PH-1:0][CNT_W-1:0] ph_run,
  output logic [NUM_PH-1:0]            ph_end
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  logic prev_q;
  logic armed_q;
  logic lvl_edge;
  assign lvl_edge = level != prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= level;
      if (!active)       armed_q <= 1'b0;
      else if (lvl_edge) armed_q <= 1'b1;
    end
  end

  // phase 0 measures low time, phase 1 measures high time
  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] res_q;
    logic             done;
    assign done = active && armed_q && lvl_edge && (prev_q == 1'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q <= '0;
        res_q <= '0;
      end else begin
        if (!active)
          run_q <= '0;
        else if (level == 1'(p))
          run_q <= lvl_edge ? CNT_W'(1) : sat_inc(run_q);
        if (done) res_q <= run_q;
      end
    end

    assign ph_res[p] = res_q;
    assign ph_run[p] = run_q;
    assign ph_end[p] = done;
  end
endmodule

// File: rtl/pwc_status.sv
module pwc_status
  import pwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] set_ev,
  input  logic [NUM_PH-1:0] clr_ev,
  input  logic [NUM_PH-1:0] irq_en,
  input  logic [NUM_PH-1:0] irq_mask,
  output logic [NUM_PH-1:0] status,
  output logic              irq
);
  function automatic logic gate_irq(input logic [NUM_PH-1:0] st, input logic [NUM_PH-1:0] en,
                                    input logic [NUM_PH-1:0] msk);
    return |(st & en & ~msk);
  endfunction

  logic [NUM_PH-1:0] st_q;
  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr_ev) | set_ev;
  end

  assign status = st_q;
  assign irq    = gate_irq(st_q, irq_en, irq_mask);
endmodule

// File: rtl/pulse_width_capture.sv
module pulse_width_capture
  import pwc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W = 32,
  parameter int WIN_W = 6,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [NUM_CH-1:0] pin_in,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic              filt_en,
  input  logic [WIN_W-1:0]  filt_win,
  input  logic [1:0]        sts_clr,
  input  logic [1:0]        irq_en,
  input  logic [1:0]        irq_mask,
  output logic [CNT_W-1:0]  hi_count,
  output logic [CNT_W-1:0]  lo_count,
  output logic [1:0]        status,
  output logic              irq
);
  logic active;
  logic sync_lvl;
  logic filt_lvl;
  logic [NUM_PH-1:0][CNT_W-1:0] ph_res;
  logic [NUM_PH-1:0][CNT_W-1:0] ph_run;
  logic [NUM_PH-1:0]            ph_end;
  logic                         hi_latch;
  logic [CNT_W-1:0]             hi_run;

  assign active = mode == MODE_CAPTURE;

  pwc_input #(
    .NUM_CH(NUM_CH), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES), .WIN_W(WIN_W)
  ) u_input (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .src_sel(src_sel),
    .filt_en(filt_en), .filt_win(filt_win), .sync_lvl(sync_lvl), .filt_lvl(filt_lvl)
  );

  pwc_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .active(active), .level(filt_lvl),
    .ph_res(ph_res), .ph_run(ph_run), .ph_end(ph_end)
  );

  pwc_status u_status (
    .clk(clk), .rst_n(rst_n), .set_ev(ph_end), .clr_ev(sts_clr),
    .irq_en(irq_en), .irq_mask(irq_mask), .status(status), .irq(irq)
  );

  assign hi_count = ph_res[PH_HI];
  assign lo_count = ph_res[PH_LO];
  assign hi_latch = ph_end[PH_HI];
  assign hi_run   = ph_run[PH_HI];
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [1:0]       sts_clr,
  input logic [1:0]       irq_mask,
  input logic [CNT_W-1:0] hi_count,
  input logic [CNT_W-1:0] lo_count,
  input logic [1:0]       status,
  input logic             irq,
  input logic             sync_lvl,
  input logic             filt_lvl,
  input logic             hi_latch,
  input logic [CNT_W-1:0] hi_run
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) |=> ($stable(hi_count) && $stable(lo_count)));

  // R4
  hi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hi_count) |-> status[1]);

  // R5
  lo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lo_count) |-> status[0]);

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&hi_run) && (mode == 2'b10)) |=> (hi_run != '0));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr[1] && !hi_latch) |=> !status[1]);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_latch |=> status[1]);

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b00) |-> !irq);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_mask) |-> !irq);

  // R10
  filt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_lvl) |-> ($past(sync_lvl) != $past(filt_lvl)));
endmodule

bind pulse_width_capture pwc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sts_clr(sts_clr), .irq_mask(irq_mask),
  .hi_count(hi_count), .lo_count(lo_count), .status(status), .irq(irq),
  .sync_lvl(sync_lvl), .filt_lvl(filt_lvl), .hi_latch(hi_latch), .hi_run(hi_run)
);

// File: tb/pulse_width_capture_test.sv
module pulse_width_capture_test;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [7:0]    pin_in = '0;
  logic [2:0]    src_sel = '0;
  logic          filt_en = 1'b0;
  logic [5:0]    filt_win = '0;
  logic [1:0]    sts_clr = '0;
  logic [1:0]    irq_en = '0;
  logic [1:0]    irq_mask = '0;
  logic [CW-1:0] hi_count;
  logic [CW-1:0] lo_count;
  logic [1:0]    status;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_width_capture #(.NUM_CH(8), .CNT_W(CW), .WIN_W(6), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pin_in(pin_in), .src_sel(src_sel),
    .filt_en(filt_en), .filt_win(filt_win), .sts_clr(sts_clr), .irq_en(irq_en),
    .irq_mask(irq_mask), .hi_count(hi_count), .lo_count(lo_count),
    .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // hold pin ch at lvl for n clock cycles, starting and ending at a negedge
  task automatic drive(input int ch, input logic lvl, input int n);
    pin_in[ch] = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_status(input logic [1:0] bits);
    sts_clr = bits;
    @(negedge clk);
    sts_clr = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 hi_count", 32'(hi_count), 0);
    chk("R1 lo_count", 32'(lo_count), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_basic;
    mode = 2'b10;
    drive(0, 1'b0, 10);
    drive(0, 1'b1, 12);
    chk("R3 first edge stores nothing", 32'(status), 0);
    chk("R3 lo untouched", 32'(lo_count), 0);
    drive(0, 1'b0, 9);
    chk("R4 high width", 32'(hi_count), 12);
    chk("R4 status bit1", 32'(status), 2);
    drive(0, 1'b1, 6);
    chk("R5 low width", 32'(lo_count), 9);
    chk("R5 status bit0", 32'(status), 3);
    drive(0, 1'b0, 10);
    chk("R4 second high width", 32'(hi_count), 6);
  endtask

  task automatic t_clear;
    clear_status(2'b10);
    chk("R7 clear bit1", 32'(status), 1);
    chk("R7 count kept", 32'(hi_count), 6);
    clear_status(2'b01);
    chk("R7 clear bit0", 32'(status), 0);
  endtask

  task automatic t_set_wins;
    drive(0, 1'b1, 10);
    clear_status(2'b11);
    pin_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    sts_clr = 2'b10;
    @(negedge clk);
    sts_clr = 2'b00;
    @(negedge clk);
    chk("R7 set wins over clear", 32'(status[1]), 1);
    drive(0, 1'b0, 8);
  endtask

  task automatic t_irq;
    drive(0, 1'b1, 7);
    drive(0, 1'b0, 8);
    chk("R8 both flags", 32'(status), 3);
    irq_en = 2'b10; irq_mask = 2'b00; @(negedge clk);
    chk("R8 enabled bit1", 32'(irq), 1);
    irq_mask = 2'b10; @(negedge clk);
    chk("R8 masked bit1", 32'(irq), 0);
    irq_en = 2'b01; irq_mask = 2'b00; @(negedge clk);
    chk("R8 enabled bit0", 32'(irq), 1);
    clear_status(2'b01);
    chk("R8 only disabled flag left", 32'(irq), 0);
    irq_en = 2'b11; irq_mask = 2'b11; @(negedge clk);
    chk("R8 all masked", 32'(irq), 0);
    irq_mask = 2'b00; @(negedge clk);
    chk("R8 unmasked", 32'(irq), 1);
    irq_en = 2'b00;
  endtask

  task automatic t_idle;
    logic [CW-1:0] h0;
    logic [CW-1:0] l0;
    clear_status(2'b11);
    h0 = hi_count;
    l0 = lo_count;
    mode = 2'b01;
    drive(0, 1'b1, 10);
    drive(0, 1'b0, 10);
    drive(0, 1'b1, 10);
    drive(0, 1'b0, 10);
    chk("R2 hi held when idle", 32'(hi_count), 32'(h0));
    chk("R2 lo held when idle", 32'(lo_count), 32'(l0));
    chk("R2 status held when idle", 32'(status), 0);
    mode = 2'b10;
    drive(0, 1'b0, 4);
    drive(0, 1'b1, 10);
    chk("R3 rearm no store", 32'(status), 0);
    drive(0, 1'b0, 10);
    chk("R3 first full phase", 32'(hi_count), 10);
    chk("R3 first full flag", 32'(status), 2);
  endtask

  task automatic t_select;
    clear_status(2'b11);
    src_sel = 3'd3;
    @(negedge clk);
    drive(0, 1'b1, 10);
    drive(0, 1'b0, 10);
    chk("R9 unselected pin ignored", 32'(status), 0);
    drive(3, 1'b1, 13);
    drive(3, 1'b0, 11);
    drive(3, 1'b1, 9);
    drive(3, 1'b0, 10);
    chk("R9 selected high", 32'(hi_count), 9);
    chk("R9 selected low", 32'(lo_count), 11);
    src_sel = 3'd0;
    @(negedge clk);
  endtask

  task automatic t_filter;
    filt_en = 1'b1;
    filt_win = 6'd4;
    drive(0, 1'b0, 4);
    clear_status(2'b11);
    drive(0, 1'b1, 3);
    drive(0, 1'b0, 12);
    chk("R10 short pulse dropped", 32'(status), 0);
    chk("R10 count kept", 32'(hi_count), 9);
    drive(0, 1'b1, 4);
    drive(0, 1'b0, 12);
    chk("R10 window length passes", 32'(hi_count), 4);
    drive(0, 1'b1, 6);
    drive(0, 1'b0, 9);
    drive(0, 1'b1, 8);
    drive(0, 1'b0, 12);
    chk("R10 high width kept", 32'(hi_count), 8);
    chk("R10 low width kept", 32'(lo_count), 9);
    filt_en = 1'b0;
    filt_win = 6'd0;
    @(negedge clk);
  endtask

  task automatic t_sat;
    drive(0, 1'b1, 300);
    drive(0, 1'b0, 12);
    chk("R6 saturated high", 32'(hi_count), 255);
    drive(0, 1'b1, 5);
    drive(0, 1'b0, 10);
    chk("R6 restart after saturate", 32'(hi_count), 5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_clear();
    t_set_wins();
    t_irq();
    t_idle();
    t_select();
    t_filter();
    t_sat();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule